// File: doc/BRIEF.md
# Hall Period Speed Lock Detector

This block watches one deglitched Hall sensor bit and times the interval between its rising edges in units of a slow timebase tick. It judges each new period against three conditions: the motor must turn faster than a programmable minimum speed, the period must stay close to the one before it, and that must go on for a programmable run of periods. When all three hold, it raises a lock level. The commutation logic uses this level to move from three-sensor commutation to single-sensor or sine commutation.

The lock level is held off while the speed-loop integrator reports saturation, unless the design is running from a duty-cycle speed input. A separate commutation-select output is forced low whenever basic mode is selected. The lock state is also driven on an active-low pin. The last measured period is visible on its own output. Disable and brake both drop lock, forget the stored period and re-arm the measurement.

Top module: `hsl_lock_detect`

## Requirements
- R1: `period_o` reports the number of timebase ticks between the two most recent rising edges of `hall_u_i`. The first rising edge after reset or a clear only starts the measurement and produces no period.
- R2: The tick counter saturates at 2^CNT_W-1 and does not wrap. A longer interval is reported as 2^CNT_W-1.
- R3: A period qualifies for speed only if it is strictly less than `min_spd_i` × 2^LIM_SHIFT ticks (256 ticks per count by default). A period that fails this test clears `lock_o` and restarts the stable-period run.
- R4: A period Pn qualifies for stability only if |Pn − Pn−1| ≤ Pn−1 >> (TOL_BASE − `tol_code_i`). With the default TOL_BASE of 9, code 0 allows 1/512 of the previous period and code 7 allows 1/4. A failing period clears `lock_o` and restarts the run. The first period after a clear has no predecessor and never qualifies.
- R5: Lock sets on the (`stable_revs_i`+1)-th consecutive period that meets both R3 and R4. It stays set while further periods qualify.
- R6: While `integ_sat_i` is 1 and `pwm_mode_i` is 0, `lock_o` is 0. When `pwm_mode_i` is 1, `integ_sat_i` has no effect. The stable-period run keeps counting during the veto.
- R7: `single_hall_o` equals `lock_o` except that it is 0 whenever `basic_i` is 1. `basic_i` does not affect `lock_o`.
- R8: `lock_n_o` is always the inverse of `lock_o`.
- R9: `enable_i` low or `brake_i` high clears `lock_o`, `single_hall_o` and `period_o` to 0 and re-arms the measurement.
- R10: After reset, `lock_o`=0, `lock_n_o`=1, `single_hall_o`=0 and `period_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Motor enable; low clears the detector |
| brake_i | input | 1 | Brake active; high clears the detector |
| hall_u_i | input | 1 | Deglitched, synchronous Hall-U bit |
| min_spd_i | input | LIM_W | Period limit, in units of 2^LIM_SHIFT ticks |
| tol_code_i | input | TOL_W | Period-to-period tolerance code |
| stable_revs_i | input | REV_W | Extra qualifying periods required before lock |
| integ_sat_i | input | 1 | Speed-loop integrator saturated |
| pwm_mode_i | input | 1 | Duty-cycle speed input selected; integrator veto ignored |
| basic_i | input | 1 | Basic commutation mode; blocks single-sensor select |
| lock_o | output | 1 | Speed lock level |
| lock_n_o | output | 1 | Active-low lock pin |
| single_hall_o | output | 1 | Single-sensor commutation permitted |
| period_o | output | CNT_W | Last measured Hall-U period in ticks |

## Verification
The bench builds the block with TICK_DIV=4, CNT_W=12 and LIM_SHIFT=4. A tick then lasts four clocks, and one limit count covers 16 ticks. These values let a few hundred clocks span realistic periods and limit boundaries. They also bring counter saturation at 4095 ticks within about 16,000 clocks. The tolerance shift keeps its default base, so the codes 0 and 7 exercise their real fractions on periods near 128 and 200 ticks.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

   // Right-shift amount applied to the previous period for a tolerance code.
   function automatic int unsigned tol_shift(input int unsigned base, input int unsigned code);
      return base - code;
   endfunction

   // Saturating increment helper width selector.
   function automatic int unsigned max_int(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hsl_tick_gen.sv
module hsl_tick_gen #(
   parameter int unsigned TICK_DIV = 500
) (
   input  logic clk_i,
   input  logic rst_n_i,
   output logic tick_o
);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("hsl_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_every_clk
      // Every clock is a tick once reset is released.
      assign tick_o = rst_n_i;
   end else begin : g_divider
      localparam int unsigned DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i)          div_q <= '0;
         else if (div_q == LAST) div_q <= '0;
         else                   div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      a_r1_tick_periodic: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/hsl_period_meter.sv
module hsl_period_meter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic             hall_i,
   output logic             per_valid_o,
   output logic [CNT_W-1:0] per_o
);

   if (CNT_W < 2) begin : g_bad_w
      $error("hsl_period_meter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             hall_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             rise;

   assign rise    = hall_i & ~hall_q;
   assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : (cnt_q + CNT_W'(tick_i));

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) hall_q <= 1'b0;
      else          hall_q <= hall_i;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         armed_q     <= 1'b0;
         cnt_q       <= '0;
         per_valid_o <= 1'b0;
         per_o       <= '0;
      end else if (clear_i) begin
         armed_q     <= 1'b0;
         cnt_q       <= '0;
         per_valid_o <= 1'b0;
      end else if (rise) begin
         armed_q     <= 1'b1;
         cnt_q       <= '0;
         per_valid_o <= armed_q;
         if (armed_q) per_o <= cnt_inc;
      end else begin
         cnt_q       <= cnt_inc;
         per_valid_o <= 1'b0;
      end
   end

   a_r2_count_saturates: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cnt_q == CNT_MAX && !rise && !clear_i) |=> (cnt_q == CNT_MAX));

   a_r1_period_on_edge: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      per_valid_o |-> $past(rise));

   a_r9_no_period_after_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      clear_i |=> !per_valid_o);

endmodule

// File: rtl/hsl_lock_qual.sv
module hsl_lock_qual
   import hsl_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned LIM_W     = 8,
   parameter int unsigned LIM_SHIFT = 8,
   parameter int unsigned TOL_W     = 3,
   parameter int unsigned TOL_BASE  = 9,
   parameter int unsigned REV_W     = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             clear_i,
   input  logic             per_valid_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [LIM_W-1:0] limit_i,
   input  logic [TOL_W-1:0] tol_i,
   input  logic [REV_W-1:0] revs_i,
   output logic             locked_o,
   output logic [CNT_W-1:0] last_per_o
);

   if (TOL_BASE < (2**TOL_W) - 1) begin : g_bad_base
      $error("hsl_lock_qual: TOL_BASE must cover every tolerance code");
   end
   if (LIM_SHIFT < 1) begin : g_bad_shift
      $error("hsl_lock_qual: LIM_SHIFT must be at least 1");
   end

   localparam int unsigned CMP_W = max_int(CNT_W, LIM_W + LIM_SHIFT);
   localparam int unsigned SH_W  = $clog2(TOL_BASE + 1);
   localparam int unsigned RUN_W = REV_W + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   logic             have_prev_q;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nxt;
   logic [CMP_W-1:0] lim_ticks;
   logic [CNT_W-1:0] diff;
   logic [CNT_W-1:0] allow;
   logic [SH_W-1:0]  shamt;
   logic             speed_ok;
   logic             tol_ok;
   logic             qual;

   assign lim_ticks = CMP_W'(limit_i) << LIM_SHIFT;
   assign speed_ok  = CMP_W'(per_i) < lim_ticks;

   assign diff  = (per_i > last_per_o) ? (per_i - last_per_o) : (last_per_o - per_i);
   assign shamt = SH_W'(tol_shift(TOL_BASE, 32'(tol_i)));
   assign allow = last_per_o >> shamt;
   assign tol_ok = (diff <= allow);

   assign qual    = speed_ok & tol_ok & have_prev_q;
   assign run_nxt = (run_q == RUN_MAX) ? RUN_MAX : (run_q + 1'b1);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         have_prev_q <= 1'b0;
         last_per_o  <= '0;
         run_q       <= '0;
         locked_o    <= 1'b0;
      end else if (clear_i) begin
         have_prev_q <= 1'b0;
         last_per_o  <= '0;
         run_q       <= '0;
         locked_o    <= 1'b0;
      end else if (per_valid_i) begin
         have_prev_q <= 1'b1;
         last_per_o  <= per_i;
         if (qual) begin
            run_q    <= run_nxt;
            locked_o <= locked_o | (run_nxt > {1'b0, revs_i});
         end else begin
            run_q    <= '0;
            locked_o <= 1'b0;
         end
      end
   end

   a_r3_slow_period_drops: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (per_valid_i && !speed_ok) |=> !locked_o);

   a_r4_drift_drops: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (per_valid_i && have_prev_q && !tol_ok) |=> !locked_o);

   a_r5_sets_on_period: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(locked_o) |-> $past(per_valid_i));

   a_r5_run_long_enough: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(locked_o) |-> (run_q > {1'b0, revs_i}));

endmodule

// File: rtl/hsl_lock_detect.sv
module hsl_lock_detect #(
   parameter int unsigned TICK_DIV  = 500,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned LIM_W     = 8,
   parameter int unsigned LIM_SHIFT = 8,
   parameter int unsigned TOL_W     = 3,
   parameter int unsigned TOL_BASE  = 9,
   parameter int unsigned REV_W     = 8
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             enable_i,
   input  logic             brake_i,
   input  logic             hall_u_i,
   input  logic [LIM_W-1:0] min_spd_i,
   input  logic [TOL_W-1:0] tol_code_i,
   input  logic [REV_W-1:0] stable_revs_i,
   input  logic             integ_sat_i,
   input  logic             pwm_mode_i,
   input  logic             basic_i,
   output logic             lock_o,
   output logic             lock_n_o,
   output logic             single_hall_o,
   output logic [CNT_W-1:0] period_o
);

   logic             clear;
   logic             tick;
   logic             per_valid;
   logic [CNT_W-1:0] per;
   logic             locked;
   logic             lock_nxt;

   assign clear = ~enable_i | brake_i;

   hsl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .tick_o  (tick)
   );

   hsl_period_meter #(.CNT_W(CNT_W)) u_meter (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .clear_i     (clear),
      .tick_i      (tick),
      .hall_i      (hall_u_i),
      .per_valid_o (per_valid),
      .per_o       (per)
   );

   hsl_lock_qual #(
      .CNT_W     (CNT_W),
      .LIM_W     (LIM_W),
      .LIM_SHIFT (LIM_SHIFT),
      .TOL_W     (TOL_W),
      .TOL_BASE  (TOL_BASE),
      .REV_W     (REV_W)
   ) u_qual (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .clear_i     (clear),
      .per_valid_i (per_valid),
      .per_i       (per),
      .limit_i     (min_spd_i),
      .tol_i       (tol_code_i),
      .revs_i      (stable_revs_i),
      .locked_o    (locked),
      .last_per_o  (period_o)
   );

   assign lock_nxt = locked & ~clear & ~(integ_sat_i & ~pwm_mode_i);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         lock_o        <= 1'b0;
         lock_n_o      <= 1'b1;
         single_hall_o <= 1'b0;
      end else begin
         lock_o        <= lock_nxt;
         lock_n_o      <= ~lock_nxt;
         single_hall_o <= lock_nxt & ~basic_i;
      end
   end

   a_r6_integ_veto: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (integ_sat_i && !pwm_mode_i) |=> !lock_o);

   a_r7_basic_blocks: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      basic_i |=> !single_hall_o);

   a_r7_select_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      single_hall_o |-> lock_o);

   a_r8_pin_inverse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      lock_n_o == !lock_o);

   a_r9_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      clear |=> (!lock_o && period_o == '0));

endmodule

// File: tb/hsl_lock_detect_tb.sv
module hsl_lock_detect_tb;

   localparam int DIV   = 4;
   localparam int CW    = 12;
   localparam int HOLD  = 8;
   localparam int NV    = 17;

   // period, limit, tol, revs, sat, pwm, basic, exp lock, exp single
   localparam int V_P   [NV] = '{128,128,130,126,131,131,131,131,131,131,131,131,131,131,131,160,163};
   localparam int V_LIM [NV] = '{ 20, 20, 20, 20, 20, 20, 20, 20, 20, 20, 20,  8,  9,  9, 20, 20, 20};
   localparam int V_TOL [NV] = '{  4,  4,  4,  4,  4,  4,  4,  4,  4,  4,  4,  4,  4,  4,  7,  7,  3};
   localparam int V_REV [NV] = '{  2,  2,  2,  2,  2,  2,  2,  2,  2,  2,  2,  2,  2,  2,  0,  0,  0};
   localparam int V_SAT [NV] = '{  0,  0,  0,  0,  0,  0,  0,  0,  1,  1,  0,  0,  0,  0,  0,  0,  0};
   localparam int V_PWM [NV] = '{  0,  0,  0,  0,  0,  0,  0,  0,  0,  1,  0,  0,  0,  0,  0,  0,  0};
   localparam int V_BAS [NV] = '{  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  1,  0,  0,  0,  0,  0,  0};
   localparam int V_LK  [NV] = '{  0,  0,  0,  1,  0,  0,  0,  1,  0,  1,  1,  0,  0,  0,  1,  1,  0};
   localparam int V_SH  [NV] = '{  0,  0,  0,  1,  0,  0,  0,  1,  0,  1,  0,  0,  0,  0,  1,  1,  0};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          brake = 1'b0;
   logic          hall = 1'b0;
   logic [7:0]    min_spd = 8'd0;
   logic [2:0]    tol_code = 3'd0;
   logic [7:0]    revs = 8'd0;
   logic          integ_sat = 1'b0;
   logic          pwm_mode = 1'b0;
   logic          basic = 1'b0;
   logic          lock;
   logic          lock_n;
   logic          single_hall;
   logic [CW-1:0] period;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hsl_lock_detect #(
      .TICK_DIV  (DIV),
      .CNT_W     (CW),
      .LIM_W     (8),
      .LIM_SHIFT (4),
      .TOL_W     (3),
      .TOL_BASE  (9),
      .REV_W     (8)
   ) u_dut (
      .clk_i         (clk),
      .rst_n_i       (rst_n),
      .enable_i      (enable),
      .brake_i       (brake),
      .hall_u_i      (hall),
      .min_spd_i     (min_spd),
      .tol_code_i    (tol_code),
      .stable_revs_i (revs),
      .integ_sat_i   (integ_sat),
      .pwm_mode_i    (pwm_mode),
      .basic_i       (basic),
      .lock_o        (lock),
      .lock_n_o      (lock_n),
      .single_hall_o (single_hall),
      .period_o      (period)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a negedge; the next rising edge of hall comes p*DIV clocks after the previous one.
   task automatic hall_period(input int p);
      hall = 1'b0;
      repeat (p * DIV - HOLD) @(negedge clk);
      hall = 1'b1;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic check_lock(input string req, input int exp_lock, input int exp_sh);
      check(req, int'(lock), exp_lock);
      check("R8 lock pin", int'(lock_n), 1 - exp_lock);
      check(req, int'(single_hall), exp_sh);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset lock", int'(lock), 0);
      check("R10 reset pin", int'(lock_n), 1);
      check("R10 reset single", int'(single_hall), 0);
      check("R10 reset period", int'(period), 0);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);
      hall_period(40);   // arming edge only (R1)
      check("R1 no period after arming edge", int'(period), 0);

      // Table walk: R1 R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         min_spd   = 8'(V_LIM[i]);
         tol_code  = 3'(V_TOL[i]);
         revs      = 8'(V_REV[i]);
         integ_sat = V_SAT[i][0];
         pwm_mode  = V_PWM[i][0];
         basic     = V_BAS[i][0];
         hall_period(V_P[i]);
         check($sformatf("R1 period vec%0d", i), int'(period), V_P[i]);
         check_lock($sformatf("R3/R4/R5/R6/R7 vec%0d", i), V_LK[i], V_SH[i]);
      end
      integ_sat = 1'b0;
      pwm_mode  = 1'b0;
      basic     = 1'b0;

      // R9 disable clears
      enable = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 disable lock", int'(lock), 0);
      check("R9 disable period", int'(period), 0);
      check("R8 pin while disabled", int'(lock_n), 1);
      enable = 1'b1;
      hall_period(50);
      check("R9 rearm edge gives no period", int'(period), 0);
      hall_period(100);
      check("R1 period after rearm", int'(period), 100);

      // R9 brake clears
      brake = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 brake period", int'(period), 0);
      check("R9 brake lock", int'(lock), 0);
      brake = 1'b0;

      // R2 saturation
      min_spd  = 8'd255;
      tol_code = 3'd0;
      revs     = 8'd0;
      hall_period(10);
      hall_period(4200);
      check("R2 saturated period", int'(period), 4095);
      check("R3 saturated period no lock", int'(lock), 0);

      // R4 code 0 is exact-match at this size, R5 with zero extra periods
      hall_period(200);
      check("R4 large step fails", int'(lock), 0);
      hall_period(200);
      check_lock("R5 revs zero locks on first qualifying", 1, 1);
      hall_period(201);
      check_lock("R4 code0 one tick drift drops", 0, 0);
      check("R1 period 201", int'(period), 201);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule